// File: doc/BRIEF.md
# Received frame group classifier

This block sorts every received MAC frame into one of forty software group codes so that later software can steer it without re-decoding the header. A header parser upstream presents one set of decoded fields per frame with a strobe: the frame-control protocol version, type and subtype, a flag for a multicast destination, a flag for a null-data-packet sounding frame, a flag raised when the PHY reported an error, and a flag telling that the PPDU was trigger-based or uplink multi-user.

The classifier evaluates a fixed ladder of rules on those fields. The highest-priority rule that matches picks the code, so every frame gets exactly one code. Management and control frames each get one code per subtype. QoS Null frames are split by whether the PPDU was trigger-based. The code is registered and appears, together with a one-cycle valid pulse, on the clock after the strobe.

Top module: `frame_group_classifier`

## Requirements
- R1: While reset is held and after it is released, `grp_valid` is 0 and `grp_code` is 0 until the first strobe.
- R2: A strobe on `in_valid` yields `grp_valid` high on the following cycle only. Without a strobe, `grp_valid` is low and `grp_code` keeps its last value whatever the field inputs do.
- R3: A frame with `in_phy_err` set gets code 37, whatever its other fields are.
- R4: Without a PHY error, a frame whose type is 3 or whose protocol version is not 0 gets code 36.
- R5: Without the two conditions above, a frame with `in_ndp` set gets code 0.
- R6: Otherwise a data frame (type 2) with subtype 4 (Null) gets code 3.
- R7: Otherwise a data frame with subtype 12 (QoS Null) gets code 38 when `in_tb_ppdu` is 0 and code 39 when it is 1.
- R8: Otherwise a management frame (type 0) gets code 4 plus its 4-bit subtype, which covers 4 to 19.
- R9: Otherwise a control frame (type 1) gets code 20 plus its subtype, which covers 20 to 35.
- R10: Any other data frame gets code 1 when `in_mcast` is 1 and code 2 when it is 0. `in_mcast` and `in_tb_ppdu` have no effect on any other rule.
- R11: Exactly one rule decides each frame, and every code delivered with `grp_valid` lies in the range 0 to 39.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: field inputs hold one frame |
| in_proto_ver | input | 2 | Frame-control protocol version |
| in_ftype | input | 2 | Frame type (0 mgmt, 1 ctrl, 2 data, 3 reserved) |
| in_subtype | input | 4 | Frame subtype |
| in_mcast | input | 1 | Destination address is group-addressed |
| in_ndp | input | 1 | Frame is a null data packet |
| in_phy_err | input | 1 | PHY reported a reception error |
| in_tb_ppdu | input | 1 | PPDU was trigger-based or uplink multi-user |
| grp_valid | output | 1 | One-cycle pulse, code is valid |
| grp_code | output | 7 | Software group code |

## Verification
The hardest situations to reach are those where several rules match together: a PHY error on a frame that is also reserved-type and NDP, or an NDP flagged on a QoS Null. Only the priority order separates the correct code from a wrong one there. The stimulus sweeps every combination of version, type, subtype and the four flags, so each overlap of rules is presented at least once. Each strobe is followed by an idle cycle with scrambled fields, to show that the code holds.

// File: rtl/fgc_pkg.sv
// Package: shared constants for the frame group classifier.
// Assumes a 4-bit subtype and a 2-bit type field as in the MAC frame control.
package fgc_pkg;
    localparam int SUB_W      = 4;
    localparam int TYPE_W     = 2;
    localparam int VER_W      = 2;
    localparam int CODE_W     = 7;

    // Frame type encodings used by the rule ladder
    localparam logic [TYPE_W-1:0] FT_MGMT = 2'd0;
    localparam logic [TYPE_W-1:0] FT_CTRL = 2'd1;
    localparam logic [TYPE_W-1:0] FT_DATA = 2'd2;
    localparam logic [TYPE_W-1:0] FT_RSVD = 2'd3;

    localparam logic [SUB_W-1:0] SUB_NULL     = 4'd4;
    localparam logic [SUB_W-1:0] SUB_QOS_NULL = 4'd12;

    // Group code values
    localparam int GC_NDP       = 0;
    localparam int GC_MCAST     = 1;
    localparam int GC_UCAST     = 2;
    localparam int GC_NULL      = 3;
    localparam int GC_MGMT_BASE = 4;
    localparam int GC_CTRL_BASE = GC_MGMT_BASE + (1 << SUB_W);
    localparam int GC_UNSUP     = GC_CTRL_BASE + (1 << SUB_W);
    localparam int GC_PHY_ERR   = GC_UNSUP + 1;
    localparam int GC_QNULL     = GC_PHY_ERR + 1;
    localparam int GC_QNULL_TB  = GC_QNULL + 1;
    localparam int GC_MAX       = GC_QNULL_TB;

    // Rule slots, index 0 is the highest priority
    localparam int RULE_PHY   = 0;
    localparam int RULE_UNSUP = 1;
    localparam int RULE_NDP   = 2;
    localparam int RULE_NULL  = 3;
    localparam int RULE_QNULL = 4;
    localparam int RULE_MGMT  = 5;
    localparam int RULE_CTRL  = 6;
    localparam int RULE_DATA  = 7;
    localparam int NRULES     = 8;

    typedef struct packed {
        logic [VER_W-1:0]  ver;
        logic [TYPE_W-1:0] ftype;
        logic [SUB_W-1:0]  sub;
        logic              mcast;
        logic              ndp;
        logic              phy_err;
        logic              tb_ppdu;
    } frame_fields_t;
endpackage

// File: rtl/fgc_rule_match.sv
// Rule matcher: evaluates every classification rule in parallel on one set
// of decoded fields and offers a candidate code per rule.
// Assumes fields are stable while the strobe is high; purely combinational.
module fgc_rule_match
    import fgc_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  frame_fields_t               fields,
    output logic [NRULES-1:0]           hit,
    output logic [NRULES-1:0][CW-1:0]   cand
);
    // Match conditions, independent of priority
    always_comb begin
        hit = '0;
        hit[RULE_PHY]   = fields.phy_err;
        hit[RULE_UNSUP] = (fields.ftype == FT_RSVD) || (fields.ver != '0);
        hit[RULE_NDP]   = fields.ndp;
        hit[RULE_NULL]  = (fields.ftype == FT_DATA) && (fields.sub == SUB_NULL);
        hit[RULE_QNULL] = (fields.ftype == FT_DATA) && (fields.sub == SUB_QOS_NULL);
        hit[RULE_MGMT]  = (fields.ftype == FT_MGMT);
        hit[RULE_CTRL]  = (fields.ftype == FT_CTRL);
        hit[RULE_DATA]  = (fields.ftype == FT_DATA);
    end

    // Candidate code for each rule
    always_comb begin
        cand = '0;
        cand[RULE_PHY]   = CW'(GC_PHY_ERR);
        cand[RULE_UNSUP] = CW'(GC_UNSUP);
        cand[RULE_NDP]   = CW'(GC_NDP);
        cand[RULE_NULL]  = CW'(GC_NULL);
        cand[RULE_QNULL] = fields.tb_ppdu ? CW'(GC_QNULL_TB) : CW'(GC_QNULL);
        cand[RULE_MGMT]  = CW'(GC_MGMT_BASE) + CW'(fields.sub);
        cand[RULE_CTRL]  = CW'(GC_CTRL_BASE) + CW'(fields.sub);
        cand[RULE_DATA]  = fields.mcast ? CW'(GC_MCAST) : CW'(GC_UCAST);
    end
endmodule

// File: rtl/fgc_priority_pick.sv
// Priority picker: grants the lowest-index matching rule and forwards its
// candidate code. Assumes index 0 carries the highest priority.
module fgc_priority_pick #(
    parameter int N  = 8,
    parameter int CW = 7
) (
    input  logic [N-1:0]          hit,
    input  logic [N-1:0][CW-1:0]  cand,
    output logic [N-1:0]          grant,
    output logic [CW-1:0]         code
);
    // Walk from lowest priority upward so the highest match wins
    always_comb begin
        grant = '0;
        code  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                code     = cand[i];
            end
        end
    end
endmodule

// File: rtl/frame_group_classifier.sv
// Top: classifies one frame per strobe and registers the group code.
// Assumes a synchronous active-low reset; code is held between strobes.
module frame_group_classifier
    import fgc_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VER_W-1:0]  in_proto_ver,
    input  logic [TYPE_W-1:0] in_ftype,
    input  logic [SUB_W-1:0]  in_subtype,
    input  logic              in_mcast,
    input  logic              in_ndp,
    input  logic              in_phy_err,
    input  logic              in_tb_ppdu,
    output logic              grp_valid,
    output logic [CW-1:0]     grp_code
);
    frame_fields_t             fields;
    logic [NRULES-1:0]         hit;
    logic [NRULES-1:0][CW-1:0] cand;
    logic [NRULES-1:0]         grant;
    logic [CW-1:0]             pick_code;

    // Bundle the port fields
    always_comb begin
        fields.ver     = in_proto_ver;
        fields.ftype   = in_ftype;
        fields.sub     = in_subtype;
        fields.mcast   = in_mcast;
        fields.ndp     = in_ndp;
        fields.phy_err = in_phy_err;
        fields.tb_ppdu = in_tb_ppdu;
    end

    fgc_rule_match #(.CW(CW)) u_match (
        .fields (fields),
        .hit    (hit),
        .cand   (cand)
    );

    fgc_priority_pick #(.N(NRULES), .CW(CW)) u_pick (
        .hit   (hit),
        .cand  (cand),
        .grant (grant),
        .code  (pick_code)
    );

    // Output register: pulse valid, load code only on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_valid <= 1'b0;
            grp_code  <= '0;
        end else begin
            grp_valid <= in_valid;
            if (in_valid) grp_code <= pick_code;
        end
    end

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> grp_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !grp_valid);
    assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(grp_code));
    assert_phy_err_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_phy_err) |=> grp_code == CW'(GC_PHY_ERR));
    assert_one_rule_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $onehot(grant));
    assert_legal_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> grp_code <= CW'(GC_MAX));
endmodule

// File: tb/tb_frame_group_classifier.sv
module tb_frame_group_classifier;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_proto_ver = '0;
    logic [1:0] in_ftype = '0;
    logic [3:0] in_subtype = '0;
    logic       in_mcast = 1'b0;
    logic       in_ndp = 1'b0;
    logic       in_phy_err = 1'b0;
    logic       in_tb_ppdu = 1'b0;
    logic       grp_valid;
    logic [6:0] grp_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frame_group_classifier dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_proto_ver(in_proto_ver), .in_ftype(in_ftype),
        .in_subtype(in_subtype), .in_mcast(in_mcast), .in_ndp(in_ndp),
        .in_phy_err(in_phy_err), .in_tb_ppdu(in_tb_ppdu),
        .grp_valid(grp_valid), .grp_code(grp_code)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference: expected code and the requirement that decides it
    function automatic int ref_code(input int v, input int t, input int s,
                                    input int m, input int n, input int p,
                                    input int tb, output string req);
        if (p != 0)              begin req = "R3";  return 37; end
        if (t == 3 || v != 0)    begin req = "R4";  return 36; end
        if (n != 0)              begin req = "R5";  return 0;  end
        if (t == 2 && s == 4)    begin req = "R6";  return 3;  end
        if (t == 2 && s == 12)   begin req = "R7";  return (tb != 0) ? 39 : 38; end
        if (t == 0)              begin req = "R8";  return 4 + s; end
        if (t == 1)              begin req = "R9";  return 20 + s; end
        req = "R10";
        return (m != 0) ? 1 : 2;
    endfunction

    task automatic drive(input int v, input int t, input int s, input int m,
                         input int n, input int p, input int tb, input bit vld);
        in_valid     = vld;
        in_proto_ver = 2'(v);
        in_ftype     = 2'(t);
        in_subtype   = 4'(s);
        in_mcast     = m[0];
        in_ndp       = n[0];
        in_phy_err   = p[0];
        in_tb_ppdu   = tb[0];
    endtask

    initial begin
        string req;
        int exp;
        int last;
        @(negedge clk);
        @(negedge clk);
        check("R1 valid in reset", int'(grp_valid), 0);
        check("R1 code in reset", int'(grp_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(grp_valid), 0);
        check("R1 code after reset", int'(grp_code), 0);

        // Exhaustive sweep, each strobe followed by an idle cycle
        for (int idx = 0; idx < 4096; idx++) begin
            int v  = (idx >> 10) & 3;
            int t  = (idx >> 8) & 3;
            int s  = (idx >> 4) & 15;
            int m  = (idx >> 3) & 1;
            int n  = (idx >> 2) & 1;
            int p  = (idx >> 1) & 1;
            int tb = idx & 1;
            drive(v, t, s, m, n, p, tb, 1'b1);
            @(negedge clk);
            exp = ref_code(v, t, s, m, n, p, tb, req);
            check({req, " code"}, int'(grp_code), exp);
            check("R2 valid pulse", int'(grp_valid), 1);
            check("R11 range", int'(grp_code <= 7'd39), 1);
            last = exp;
            drive(3 - v, 3 - t, 15 - s, 1 - m, 1 - n, 1 - p, 1 - tb, 1'b0);
            @(negedge clk);
            check("R2 valid low when idle", int'(grp_valid), 0);
            check("R2 code held when idle", int'(grp_code), last);
        end

        // Back-to-back strobes: mgmt then ctrl then data, R8 R9 R10
        for (int s = 0; s < 16; s++) begin
            drive(0, s % 3, s, s % 2, 0, 0, 1, 1'b1);
            @(negedge clk);
            exp = ref_code(0, s % 3, s, s % 2, 0, 0, 1, req);
            check({req, " back-to-back"}, int'(grp_code), exp);
            check("R2 valid back-to-back", int'(grp_valid), 1);
        end
        drive(0, 0, 0, 0, 0, 0, 0, 1'b0);
        @(negedge clk);
        check("R2 valid drops", int'(grp_valid), 0);

        // Reset mid-stream clears outputs (R1)
        drive(0, 1, 15, 0, 0, 0, 0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 valid on reset", int'(grp_valid), 0);
        check("R1 code on reset", int'(grp_code), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule